// File: doc/BRIEF.md
# Reloadable 16-bit Down-Counter Timer with Pulse Output

This block is a 16-bit down-counter paired with a reload register. Software reaches it through an 8-bit register port. Each count pulse decrements the counter. When the counter is already at zero, the next count pulse reloads it from the reload register instead, and counting carries on. This makes the period programmable as (reload + 1) count pulses. Every underflow sets a sticky interrupt request flag.

Count pulses come from one of two sources. The first is a power-of-two prescaler on the system clock. The second is the rising or falling edges of an external event input, which is synchronised inside the block. In pulse-output mode, an output level toggles on each underflow, so the block produces a square wave. The same bit of the control register that selects the event edge also sets the starting level of that wave.

A 16-bit value cannot be moved in one 8-bit access, so byte buffers make the transfer atomic. A read takes the high byte first, and that read freezes the low byte for the read that follows. A write sends the low byte first into a buffer, and the high-byte write then commits all 16 bits in one clock.

Top module: `reload_timer16`

## Requirements
- R1: When counting is enabled, each count pulse decrements the counter. A count pulse that finds the counter at 0x0000 reloads it from the reload register, so underflows repeat every (reload+1) count pulses.
- R2: Each underflow sets the interrupt flag. The flag appears on `irq_flag` and as bit 0 of address 4. It stays at 1 until a write to address 4 with bit 0 = 0 clears it. Writing bit 0 = 1 has no effect, and an underflow in the same cycle as a clear wins.
- R3: A read of address 1 returns counter bits 15:8 and captures bits 7:0 at the same moment. A later read of address 0 returns the captured byte, even if the counter has moved since.
- R4: A write to address 0 only buffers the low byte. A write to address 1 forms {data, buffered low byte}. While the timer is stopped, that value loads both the reload register and the counter.
- R5: While the timer is running, a write to address 1 updates only the reload register. The counter picks up the new value at its next underflow.
- R6: The control register sits at address 2. Bits 2:0 select the mode (000 counts, 001 counts with pulse output), bit 5 is the edge/polarity select, bit 6 = 1 stops counting, and bit 7 = 1 selects external events. After reset the control register reads 0x40, the counter and reload register read 0xFFFF, and the flag is 0.
- R7: The value s in address 3 bits 3:0 makes internal count pulses occur every 2^(s+1) clocks. Any s of 9 or more gives every 1024 clocks.
- R8: With bit 7 = 1, the counter counts rising edges of `evt_in` when bit 5 = 0 and falling edges when bit 5 = 1. The input passes through a two-flop synchroniser, and each edge yields exactly one count pulse.
- R9: `pulse_out` is 1 after reset. Writing address 1 sets it to the inverse of bit 5. Writing the control register with a changed bit 5 inverts it. In mode 001 it toggles on every underflow.
- R10: Mode codes other than 000 and 001 suspend counting. The counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| evt_in | input | 1 | External event input (asynchronous) |
| pulse_out | output | 1 | Pulse output level |
| irq_flag | output | 1 | Sticky underflow interrupt request |

## Verification
The bench sweeps all ten prescaler settings against several reload values and measures the spacing between output toggles. A prescaler that is off by one, or a reload that fires one pulse early or late, shows up as a period other than (reload+1)*2^(s+1). Read capture is checked by letting an event decrement the counter between the high and low reads. A design that reads the low byte live returns the new value instead of the frozen one. A running write is followed by a reading of the counter before and after the next underflow. This catches a design that writes the counter directly, or one that never reloads the new value. Other cases covered: output polarity on writes and on edge-select changes, falling-edge-only counting, and flag clears that use the wrong data bit.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SRC    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;

  localparam int CTRL_POL  = 5;
  localparam int CTRL_STOP = 6;
  localparam int CTRL_EXT  = 7;

  localparam logic [2:0] MODE_COUNT = 3'b000;
  localparam logic [2:0] MODE_PULSE = 3'b001;

  localparam logic [7:0] CTRL_RESET = 8'h40;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int STAGES = 10,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(STAGES - 1);

  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] mask;
  logic [SEL_W-1:0]  sel_eff;

  assign sel_eff = (sel >= SEL_MAX) ? SEL_MAX : sel;

  for (genvar i = 0; i < STAGES; i++) begin : g_mask
    assign mask[i] = (SEL_W'(i) <= sel_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick = &(div_q | ~mask);
endmodule

// File: rtl/tmr_event_sync.sv
module tmr_event_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  input  logic fall_sel,
  output logic evt_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], evt_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise      = sync_q[STAGES-1] & ~prev_q;
  assign fall      = ~sync_q[STAGES-1] & prev_q;
  assign evt_pulse = fall_sel ? fall : rise;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             running,
  input  logic             pulse_mode,
  input  logic             pol,
  input  logic             wr_commit,
  input  logic [CNT_W-1:0] wr_value,
  input  logic             pol_flip,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             lvl_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q, reload_q, reload_nxt;
  logic             irq_q, lvl_q;

  assign uflow_o    = count_en && (cnt_q == '0);
  assign reload_nxt = wr_commit ? wr_value : reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '1;
      reload_q <= '1;
      irq_q    <= 1'b0;
      lvl_q    <= 1'b1;
    end else begin
      reload_q <= reload_nxt;
      if (wr_commit && !running)
        cnt_q <= wr_value;
      else if (count_en)
        cnt_q <= (cnt_q == '0) ? reload_nxt : cnt_q - 1'b1;

      if (uflow_o)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (wr_commit) lvl_q <= ~pol;
      else           lvl_q <= lvl_q ^ pol_flip ^ (uflow_o & pulse_mode);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import timer16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_STAGES  = 10,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_in,
  output logic              pulse_out,
  output logic              irq_flag
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] ctrl_q, wbuf_q, hold_q, rdata_q;
  logic [SEL_W-1:0]  src_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  wr_value;
  logic tick, evt_pulse, running, pulse_mode, mode_ok, count_en;
  logic wr_commit, pol_flip, irq_clr, uflow, irq, lvl;

  assign running    = !ctrl_q[CTRL_STOP];
  assign pulse_mode = (ctrl_q[2:0] == MODE_PULSE);
  assign mode_ok    = (ctrl_q[2:0] == MODE_COUNT) || pulse_mode;
  assign count_en   = running && mode_ok && (ctrl_q[CTRL_EXT] ? evt_pulse : tick);

  assign wr_commit = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_value  = {bus_wdata, wbuf_q};
  assign pol_flip  = bus_wr && (bus_addr == A_CTRL) &&
                     (bus_wdata[CTRL_POL] != ctrl_q[CTRL_POL]);
  assign irq_clr   = bus_wr && (bus_addr == A_FLAG) && !bus_wdata[0];

  tmr_prescaler #(.STAGES(PRE_STAGES), .SEL_W(SEL_W)) u_pre (
    .clk (clk), .rst (rst), .sel (src_q), .tick (tick)
  );

  tmr_event_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .evt_in (evt_in),
    .fall_sel (ctrl_q[CTRL_POL]), .evt_pulse (evt_pulse)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk (clk), .rst (rst), .count_en (count_en), .running (running),
    .pulse_mode (pulse_mode), .pol (ctrl_q[CTRL_POL]),
    .wr_commit (wr_commit), .wr_value (wr_value), .pol_flip (pol_flip),
    .irq_clr (irq_clr), .cnt_o (cnt), .irq_o (irq), .lvl_o (lvl),
    .uflow_o (uflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      src_q   <= '0;
      wbuf_q  <= '1;
      hold_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CNT_LO: wbuf_q <= bus_wdata;
          A_CTRL:   ctrl_q <= bus_wdata;
          A_SRC:    src_q  <= bus_wdata[SEL_W-1:0];
          default:  ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          A_CNT_LO: rdata_q <= hold_q;
          A_CNT_HI: begin
            rdata_q <= cnt[CNT_W-1:DATA_W];
            hold_q  <= cnt[DATA_W-1:0];
          end
          A_CTRL:   rdata_q <= ctrl_q;
          A_SRC:    rdata_q <= DATA_W'(src_q);
          A_FLAG:   rdata_q <= DATA_W'(irq);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign pulse_out = lvl;
  assign irq_flag  = irq;
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] wr_value,
  input logic             count_en,
  input logic             running,
  input logic             wr_commit,
  input logic             pol_flip,
  input logic             pulse_mode,
  input logic             uflow,
  input logic             irq_clr,
  input logic             irq_flag,
  input logic             pulse_out
);
  assert_decrement_R1: assert property (@(posedge clk) disable iff (rst)
    (count_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    uflow |=> irq_flag);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_stopped_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !running) |=> (cnt == $past(wr_value)));

  assert_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (uflow && pulse_mode && !wr_commit && !pol_flip) |=> (pulse_out != $past(pulse_out)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !(wr_commit && !running)) |=> $stable(cnt));
endmodule

bind reload_timer16 reload_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst (rst), .cnt (cnt), .wr_value (wr_value),
  .count_en (count_en), .running (running), .wr_commit (wr_commit),
  .pol_flip (pol_flip), .pulse_mode (pulse_mode), .uflow (uflow),
  .irq_clr (irq_clr), .irq_flag (irq_flag), .pulse_out (pulse_out)
);

// File: tb/test_reload_timer16.sv
module test_reload_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       evt_in = 1'b0;
  logic       pulse_out;
  logic       irq_flag;

  int errors = 0;
  int checks = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reload_timer16 i_reload_timer16 (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .evt_in (evt_in), .pulse_out (pulse_out), .irq_flag (irq_flag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd1, h); rd(3'd0, l); v = {h, l};
  endtask

  task automatic wait_toggle(output longint t);
    logic p;
    @(negedge clk); p = pulse_out;
    while (pulse_out == p) @(negedge clk);
    t = cyc;
  endtask

  task automatic evt_edge(input logic v);
    @(negedge clk); evt_in = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    longint t0, t1, t2;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6 reset state
    rd(3'd2, b);  check("R6 ctrl reset", b, 8'h40);
    rd16(v);      check("R6 counter reset", v, 16'hFFFF);
    rd(3'd4, b);  check("R6 flag reset", b, 0);
    check("R9 pulse_out reset", pulse_out, 1);
    check("R6 irq reset", irq_flag, 0);

    // R4: low-byte write alone changes nothing, high commits
    wr(3'd0, 8'h78);
    rd16(v);      check("R4 low-only write buffered", v, 16'hFFFF);
    wr(3'd1, 8'h56);
    rd16(v);      check("R4 stopped commit", v, 16'h5678);

    // R1 R7 R9: period sweep in pulse mode
    for (int s = 0; s < 10; s++) begin
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? 0 : (k == 1) ? 1 : 5;
        wr(3'd2, 8'h41);
        wr(3'd3, 8'(s));
        wr16(16'(n));
        wr(3'd2, 8'h01);
        wait_toggle(t0); wait_toggle(t1); wait_toggle(t2);
        check($sformatf("R1/R7 period s=%0d n=%0d", s, n), t2 - t1, (n + 1) * (2 ** (s + 1)));
      end
    end
    // R7: select above 9 saturates at 1024
    wr(3'd2, 8'h41); wr(3'd3, 8'd13); wr16(16'd0); wr(3'd2, 8'h01);
    wait_toggle(t0); wait_toggle(t1); wait_toggle(t2);
    check("R7 saturated select", t2 - t1, 1024);

    // R2: flag set and sticky, clear semantics
    wr(3'd2, 8'h41);
    check("R2 flag set by underflow", irq_flag, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, b);  check("R2 write 1 no effect", b, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, b);  check("R2 clear by writing 0", b, 0);
    repeat (50) @(negedge clk);
    check("R2 stays clear while stopped", irq_flag, 0);

    // R5: running write goes to reload only
    wr(3'd3, 8'd0); wr16(16'd3); wr(3'd2, 8'h00);
    wr16(16'h0100);
    rd16(v);      check("R5 running write not in counter", v[15:8], 0);
    repeat (40) @(negedge clk);
    wr(3'd2, 8'h40);
    rd16(v);
    check("R5 reload after underflow", (v <= 16'h0100 && v >= 16'h00D0), 1);

    // R10: unsupported mode code holds counter
    wr16(16'd50); wr(3'd2, 8'h02);
    repeat (200) @(negedge clk);
    rd16(v);      check("R10 other mode holds", v, 50);

    // R8: rising edges counted
    wr(3'd2, 8'h40); wr16(16'd20); wr(3'd2, 8'h80);
    for (int i = 0; i < 4; i++) begin evt_edge(1'b1); evt_edge(1'b0); end
    rd16(v);      check("R8 rising edges", v, 16);
    // R8: falling edges only
    wr(3'd2, 8'hC0); wr16(16'd10); wr(3'd2, 8'hA0);
    evt_edge(1'b1);
    rd16(v);      check("R8 rising ignored in falling mode", v, 10);
    evt_edge(1'b0);
    rd16(v);      check("R8 falling counted", v, 9);
    for (int i = 0; i < 2; i++) begin evt_edge(1'b1); evt_edge(1'b0); end
    rd16(v);      check("R8 falling edges total", v, 7);

    // R3: low byte captured at high read
    wr(3'd2, 8'hC0); wr16(16'h1234); wr(3'd2, 8'h80);
    rd(3'd1, b);  check("R3 high byte", b, 8'h12);
    evt_edge(1'b1); evt_edge(1'b0);
    rd(3'd0, b);  check("R3 captured low byte", b, 8'h34);
    rd16(v);      check("R3 fresh read", v, 16'h1233);

    // R9: polarity and reinitialisation
    wr(3'd2, 8'h41);
    wr16(16'd5);  check("R9 write level bit5=0", pulse_out, 1);
    wr(3'd2, 8'h61);
    check("R9 bit5 change inverts", pulse_out, 0);
    wr(3'd2, 8'h61);
    check("R9 same bit5 no change", pulse_out, 0);
    wr16(16'd5);  check("R9 write level bit5=1", pulse_out, 0);
    wr(3'd2, 8'h41);
    check("R9 bit5 back inverts", pulse_out, 1);
    wr(3'd2, 8'h61);
    wr(3'd2, 8'h21);
    wait_toggle(t0);
    check("R9 starts low then toggles high", pulse_out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule